// File: doc/BRIEF.md
# Shunt Current and Power Arithmetic Engine

This block is the arithmetic stage that follows a measurement sequencer in a current-sense monitor. The sequencer hands it an averaged shunt reading, a bus-voltage reading, a calibration word, the shunt gain range and the bus range, and pulses `start`. The engine clamps the shunt value to the selected gain range and stores it in two's complement. It packs the bus reading together with two status flags into a bus word. It then derives a scaled current and a scaled power figure.

Current is the clamped shunt value times the calibration word, divided by 4096, with the result truncated toward zero. Power is the unsaturated current magnitude times the bus value, divided by 5000. A shift-add multiplier forms each product over several cycles, and a restoring divider performs the division by 5000. When all four result words change together, the engine pulses `done` for one cycle. Conversion into physical units is left to software.

Top module: `pwr_calc_engine`

## Requirements
- R1: The shunt word is the signed input clamped to ±4000 counts for gain code 0, ±8000 for code 1, ±16000 for code 2 and ±32000 for code 3. It is stored as 16-bit two's complement, so the sign fills every upper bit.
- R2: The bus word carries the bus value in bits 15:3, and bit 2 always reads 0. With `range_hi` low, the most significant bus input bit is dropped, so bit 15 reads 0. The masked value is also the one that enters the power product.
- R3: The stored calibration word (`cal_reg`) is the input with bit 0 forced to 0. That masked word is the one used for the current product.
- R4: Current is (clamped shunt × calibration) / 4096, truncated toward zero and signed. A positive magnitude above 32767 saturates to 7FFFh. A negative magnitude above 32768 saturates to 8000h. A result of exactly −32768 is not an overflow.
- R5: Power is (unsaturated current magnitude × bus value) / 5000, truncated and unsigned. A result above 65535 saturates to FFFFh.
- R6: Bit 0 of the bus word is the overflow flag. It is 1 exactly when the current or the power of the last computation exceeded its range.
- R7: Bit 1 of the bus word is the ready flag. It clears on the edge that accepts `start` and sets when results are written. `done` is a single-cycle pulse, and all result words update on that cycle.
- R8: A `start` pulse that arrives while `busy` is high is ignored. It produces no extra `done`, and `cal_reg` and the results are left untouched.
- R9: With a calibration word of 0 or 1, both current and power are 0.
- R10: After reset, every output word is 0 and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| shunt_in | input | 17 | Averaged shunt reading, signed, 10 µV counts |
| bus_in | input | 13 | Bus reading, unsigned |
| cal_in | input | 16 | Calibration word |
| gain | input | 2 | Shunt gain range code |
| range_hi | input | 1 | 1 = wide bus range, 0 = narrow bus range |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| shunt_reg | output | 16 | Formatted shunt word |
| bus_reg | output | 16 | Bus data, ready flag (bit 1), overflow flag (bit 0) |
| current_reg | output | 16 | Signed scaled current |
| power_reg | output | 16 | Unsigned scaled power |
| cal_reg | output | 16 | Calibration word in use |

## Verification
The properties assume that the sequencer raises `start` as a single-cycle pulse. They also assume that it holds the operand inputs steady on the accepting edge, and that it drives inputs only away from the clock edge. The bench drives every operand and `start` on the falling edge and drops `start` one cycle later. It waits for `busy` to fall before it issues the next accepted job. The only deliberate violation is a second pulse fired into the middle of a running job, which exercises the ignore rule.

// File: rtl/pwr_calc_pkg.sv
package pwr_calc_pkg;

    localparam int DEF_RAW_W     = 17;
    localparam int DEF_REG_W     = 16;
    localparam int DEF_BUS_W     = 13;
    localparam int DEF_CAL_W     = 16;
    localparam int DEF_CUR_SHIFT = 12;
    localparam int DEF_PWR_DIV   = 5000;
    localparam int BASE_LIMIT    = 4000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL_I,
        ST_MUL_P,
        ST_DIV_P
    } eng_state_e;

    // Clamp limit doubles with each gain code step.
    function automatic logic [DEF_REG_W-1:0] gain_limit(input logic [1:0] code);
        return DEF_REG_W'(BASE_LIMIT) << code;
    endfunction

endpackage

// File: rtl/pc_shunt_fmt.sv
module pc_shunt_fmt
    import pwr_calc_pkg::*;
#(
    parameter int RAW_W = DEF_RAW_W,
    parameter int REG_W = DEF_REG_W
) (
    input  logic signed [RAW_W-1:0] raw,
    input  logic        [1:0]       gain,
    output logic        [REG_W-1:0] value,
    output logic        [REG_W-1:0] magnitude,
    output logic                    neg
);
    localparam int XW = ((RAW_W > REG_W) ? RAW_W : REG_W) + 2;

    logic signed [XW-1:0] raw_x;
    logic signed [XW-1:0] lim_x;

    always_comb begin
        raw_x = XW'(raw);
        lim_x = XW'(gain_limit(gain));
        if (raw_x > lim_x) begin
            value = REG_W'(lim_x);
        end else if (raw_x < -lim_x) begin
            value = REG_W'(-lim_x);
        end else begin
            value = REG_W'(raw_x);
        end
        neg       = value[REG_W-1];
        magnitude = neg ? (~value + REG_W'(1)) : value;
    end

endmodule

// File: rtl/pc_shift_mul.sv
module pc_shift_mul #(
    parameter int A_W  = 16,
    parameter int B_W  = 16,
    parameter int DROP = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      go,
    input  logic [A_W-1:0]            a,
    input  logic [B_W-1:0]            b,
    output logic                      done,
    output logic [A_W+B_W-DROP-1:0]   product
);
    localparam int P_W = A_W + B_W;
    localparam int C_W = $clog2(B_W + 1);

    logic [P_W-1:0] acc;
    logic [P_W-1:0] mcand;
    logic [B_W-1:0] mplier;
    logic [C_W-1:0] cnt;
    logic           run;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                acc    <= '0;
                mcand  <= P_W'(a);
                mplier <= b;
                cnt    <= C_W'(B_W);
                run    <= 1'b1;
            end else if (run) begin
                if (mplier[0]) begin
                    acc <= acc + mcand;
                end
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt - C_W'(1);
                if (cnt == C_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign product = acc[P_W-1:DROP];

endmodule

// File: rtl/pc_restore_div.sv
module pc_restore_div #(
    parameter int N_W = 33,
    parameter int D_W = 13
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           done,
    output logic [N_W-1:0] quotient
);
    localparam int C_W = $clog2(N_W + 1);

    logic [D_W-1:0] rem;
    logic [D_W:0]   trial;
    logic           fits;
    logic [C_W-1:0] cnt;
    logic           run;

    always_comb begin
        trial = {rem, quotient[N_W-1]};
        fits  = (trial >= {1'b0, divisor});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem      <= '0;
            quotient <= '0;
            cnt      <= '0;
            run      <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem      <= '0;
                quotient <= dividend;
                cnt      <= C_W'(N_W);
                run      <= 1'b1;
            end else if (run) begin
                rem      <= fits ? D_W'(trial - {1'b0, divisor}) : D_W'(trial);
                quotient <= {quotient[N_W-2:0], fits};
                cnt      <= cnt - C_W'(1);
                if (cnt == C_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwr_calc_engine.sv
module pwr_calc_engine
    import pwr_calc_pkg::*;
#(
    parameter int RAW_W     = DEF_RAW_W,
    parameter int REG_W     = DEF_REG_W,
    parameter int BUS_W     = DEF_BUS_W,
    parameter int CAL_W     = DEF_CAL_W,
    parameter int CUR_SHIFT = DEF_CUR_SHIFT,
    parameter int PWR_DIV   = DEF_PWR_DIV
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [RAW_W-1:0] shunt_in,
    input  logic        [BUS_W-1:0] bus_in,
    input  logic        [CAL_W-1:0] cal_in,
    input  logic        [1:0]       gain,
    input  logic                    range_hi,
    output logic                    busy,
    output logic                    done,
    output logic        [REG_W-1:0] shunt_reg,
    output logic        [REG_W-1:0] bus_reg,
    output logic        [REG_W-1:0] current_reg,
    output logic        [REG_W-1:0] power_reg,
    output logic        [CAL_W-1:0] cal_reg
);
    localparam int CM_W = REG_W + CAL_W - CUR_SHIFT;   // unsaturated current magnitude
    localparam int PP_W = CM_W + BUS_W;                // power product
    localparam int DV_W = $clog2(PWR_DIV + 1);
    localparam logic [CAL_W-1:0] CAL_MASK = ~CAL_W'(1);
    localparam logic [CM_W-1:0]  POS_LIM  = CM_W'(2 ** (REG_W - 1) - 1);
    localparam logic [CM_W-1:0]  NEG_LIM  = CM_W'(2 ** (REG_W - 1));
    localparam logic [PP_W-1:0]  PWR_LIM  = PP_W'(2 ** REG_W - 1);

    eng_state_e       state;
    logic [REG_W-1:0] fmt_val, fmt_mag;
    logic             fmt_neg;
    logic [REG_W-1:0] shunt_q, mag_q;
    logic             neg_q;
    logic [BUS_W-1:0] bus_eff, bus_q, bus_out_q;
    logic [CM_W-1:0]  cur_mag_q, prod_i;
    logic [PP_W-1:0]  prod_p, quo;
    logic             go_i, go_p, go_d;
    logic             done_i, done_p, done_d;
    logic             ready_q, ovf_q;
    logic             cur_ovf, pwr_ovf;
    logic [REG_W-1:0] cur_val, pwr_val;

    pc_shunt_fmt #(.RAW_W(RAW_W), .REG_W(REG_W)) u_fmt (
        .raw(shunt_in), .gain(gain),
        .value(fmt_val), .magnitude(fmt_mag), .neg(fmt_neg)
    );

    pc_shift_mul #(.A_W(REG_W), .B_W(CAL_W), .DROP(CUR_SHIFT)) u_mul_i (
        .clk(clk), .rst(rst), .go(go_i), .a(mag_q), .b(cal_reg),
        .done(done_i), .product(prod_i)
    );

    pc_shift_mul #(.A_W(CM_W), .B_W(BUS_W), .DROP(0)) u_mul_p (
        .clk(clk), .rst(rst), .go(go_p), .a(cur_mag_q), .b(bus_q),
        .done(done_p), .product(prod_p)
    );

    pc_restore_div #(.N_W(PP_W), .D_W(DV_W)) u_div (
        .clk(clk), .rst(rst), .go(go_d), .dividend(prod_p),
        .divisor(DV_W'(PWR_DIV)), .done(done_d), .quotient(quo)
    );

    always_comb begin
        bus_eff = range_hi ? bus_in : {1'b0, bus_in[BUS_W-2:0]};
        cur_ovf = neg_q ? (cur_mag_q > NEG_LIM) : (cur_mag_q > POS_LIM);
        if (cur_ovf) begin
            cur_val = neg_q ? REG_W'(NEG_LIM) : REG_W'(POS_LIM);
        end else begin
            cur_val = neg_q ? REG_W'(~cur_mag_q + CM_W'(1)) : REG_W'(cur_mag_q);
        end
        pwr_ovf = (quo > PWR_LIM);
        pwr_val = pwr_ovf ? '1 : REG_W'(quo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            shunt_q     <= '0;
            mag_q       <= '0;
            neg_q       <= 1'b0;
            bus_q       <= '0;
            cur_mag_q   <= '0;
            cal_reg     <= '0;
            go_i        <= 1'b0;
            go_p        <= 1'b0;
            go_d        <= 1'b0;
            done        <= 1'b0;
            ready_q     <= 1'b0;
            ovf_q       <= 1'b0;
            shunt_reg   <= '0;
            bus_out_q   <= '0;
            current_reg <= '0;
            power_reg   <= '0;
        end else begin
            go_i <= 1'b0;
            go_p <= 1'b0;
            go_d <= 1'b0;
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    shunt_q <= fmt_val;
                    mag_q   <= fmt_mag;
                    neg_q   <= fmt_neg;
                    bus_q   <= bus_eff;
                    cal_reg <= cal_in & CAL_MASK;
                    ready_q <= 1'b0;
                    go_i    <= 1'b1;
                    state   <= ST_MUL_I;
                end
                ST_MUL_I: if (done_i) begin
                    cur_mag_q <= prod_i;
                    go_p      <= 1'b1;
                    state     <= ST_MUL_P;
                end
                ST_MUL_P: if (done_p) begin
                    go_d  <= 1'b1;
                    state <= ST_DIV_P;
                end
                ST_DIV_P: if (done_d) begin
                    shunt_reg   <= shunt_q;
                    bus_out_q   <= bus_q;
                    current_reg <= cur_val;
                    power_reg   <= pwr_val;
                    ovf_q       <= cur_ovf | pwr_ovf;
                    ready_q     <= 1'b1;
                    done        <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign bus_reg = {bus_out_q, 1'b0, ready_q, ovf_q};

endmodule

// File: rtl/pc_engine_chk.sv
module pc_engine_chk #(
    parameter int REG_W = 16,
    parameter int CAL_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [REG_W-1:0] shunt_reg,
    input logic [REG_W-1:0] bus_reg,
    input logic [REG_W-1:0] current_reg,
    input logic [REG_W-1:0] power_reg,
    input logic [CAL_W-1:0] cal_reg
);
    localparam int SHUNT_MAX = 32000;
    localparam logic [REG_W-1:0] CUR_HI = {1'b0, {(REG_W-1){1'b1}}};
    localparam logic [REG_W-1:0] CUR_LO = {1'b1, {(REG_W-1){1'b0}}};

    AST_SHUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        ($signed(shunt_reg) <= SHUNT_MAX) && ($signed(shunt_reg) >= -SHUNT_MAX)); // R1
    AST_BUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_reg[2]); // R2
    AST_CAL_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !cal_reg[0]); // R3
    AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (rst)
        done && bus_reg[0] |-> (current_reg == CUR_HI) || (current_reg == CUR_LO)
                               || (power_reg == '1)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> bus_reg[1] && !busy); // R7
    AST_READY_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !bus_reg[1]); // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(cal_reg)); // R8
    AST_ZERO_CAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        done && (cal_reg == '0) |-> (current_reg == '0) && (power_reg == '0)); // R9
endmodule

bind pwr_calc_engine pc_engine_chk #(.REG_W(REG_W), .CAL_W(CAL_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .shunt_reg(shunt_reg), .bus_reg(bus_reg), .current_reg(current_reg),
    .power_reg(power_reg), .cal_reg(cal_reg)
);

// File: tb/pwr_calc_engine_bench.sv
module pwr_calc_engine_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic signed [16:0] shunt_in = '0;
    logic [12:0]        bus_in = '0;
    logic [15:0]        cal_in = '0;
    logic [1:0]         gain = '0;
    logic               range_hi = 1'b1;
    logic               busy, done;
    logic [15:0]        shunt_reg, bus_reg, current_reg, power_reg, cal_reg;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] shunt;
        logic [15:0] busw;
        logic [15:0] cur;
        logic [15:0] pwr;
        logic [15:0] cal;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    pwr_calc_engine u_pwr_calc_engine (
        .clk(clk), .rst(rst), .start(start), .shunt_in(shunt_in),
        .bus_in(bus_in), .cal_in(cal_in), .gain(gain), .range_hi(range_hi),
        .busy(busy), .done(done), .shunt_reg(shunt_reg), .bus_reg(bus_reg),
        .current_reg(current_reg), .power_reg(power_reg), .cal_reg(cal_reg)
    );

    task automatic chk(string req, string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
        end
    endtask

    function automatic exp_t model(int raw, int busv_in, int cal, int g, bit rng, string tag);
        exp_t e;
        int lim, s, c, busv, mag;
        longint cm, p;
        bit neg, covf, povf;
        lim = 4000 << g;
        s = (raw > lim) ? lim : ((raw < -lim) ? -lim : raw);
        c = cal & 32'hFFFE;
        neg = (s < 0);
        mag = neg ? -s : s;
        cm = (longint'(mag) * c) >>> 12;
        covf = neg ? (cm > 32768) : (cm > 32767);
        busv = rng ? busv_in : (busv_in & 32'hFFF);
        p = (cm * busv) / 5000;
        povf = (p > 65535);
        e.shunt = 16'(s);
        if (covf) e.cur = neg ? 16'h8000 : 16'h7FFF;
        else      e.cur = neg ? 16'(-cm) : 16'(cm);
        e.pwr = povf ? 16'hFFFF : 16'(p);
        e.busw = 16'((busv << 3) | 2 | ((covf || povf) ? 1 : 0));
        e.cal = 16'(c);
        e.tag = tag;
        return e;
    endfunction

    // Driver: pushes the expected item, then pulses start.
    task automatic run_job(int raw, int bv, int cal, int g, bit rng, string tag);
        while (busy) @(negedge clk);
        sb_q.push_back(model(raw, bv, cal, g, rng, tag));
        shunt_in = 17'(raw);
        bus_in   = 13'(bv);
        cal_in   = 16'(cal);
        gain     = 2'(g);
        range_hi = rng;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7", {tag, " ready cleared"}, {15'd0, bus_reg[1]}, 16'd0);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops and compares when the engine reports completion.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                chk("R8", "unexpected done", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R1", e.tag, shunt_reg, e.shunt);
                chk("R2 R6 R7", e.tag, bus_reg, e.busw);
                chk("R4 R9", e.tag, current_reg, e.cur);
                chk("R5 R9", e.tag, power_reg, e.pwr);
                chk("R3", e.tag, cal_reg, e.cal);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10", "reset shunt", shunt_reg, 16'd0);
        chk("R10", "reset bus", bus_reg, 16'd0);
        chk("R10", "reset cur", current_reg, 16'd0);
        chk("R10", "reset pwr", power_reg, 16'd0);
        chk("R10", "reset flags", {14'd0, busy, done}, 16'd0);

        run_job(1000, 1000, 4096, 3, 1'b1, "basic");
        run_job(1000, 1000, 4097, 3, 1'b1, "odd cal R3");
        run_job(50000, 200, 4096, 0, 1'b1, "clamp pos g0 R1");
        run_job(-50000, 200, 4096, 1, 1'b1, "clamp neg g1 R1");
        run_job(16001, 300, 2048, 2, 1'b1, "clamp g2 R1");
        run_job(-40000, 300, 2048, 3, 1'b1, "clamp g3 R1");
        run_job(-1234, 777, 10000, 3, 1'b1, "negative R4");
        run_job(32000, 100, 65534, 3, 1'b1, "pos ovf R4 R6");
        run_job(-32000, 100, 65534, 3, 1'b1, "neg ovf R4 R6");
        run_job(-16384, 5, 8192, 3, 1'b1, "edge -32768 R4");
        run_job(16384, 5, 8192, 3, 1'b1, "edge +32768 R4");
        run_job(32000, 8191, 8192, 3, 1'b1, "power ovf R5");
        run_job(32000, 8191, 4096, 3, 1'b1, "power big R5");
        run_job(5000, 8191, 4096, 3, 1'b0, "narrow bus R2");
        run_job(12345, 4000, 0, 3, 1'b1, "cal zero R9");
        run_job(12345, 4000, 1, 3, 1'b1, "cal one R9");

        // R8: second start while busy is ignored
        while (busy) @(negedge clk);
        sb_q.push_back(model(2000, 500, 6000, 3, 1'b1, "busy start R8"));
        shunt_in = 17'sd2000; bus_in = 13'd500; cal_in = 16'd6000;
        gain = 2'd3; range_hi = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        shunt_in = 17'sd9; bus_in = 13'd9; cal_in = 16'd9000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "cal kept during busy", cal_reg, 16'd6000);
        while (busy) @(negedge clk);
        repeat (100) @(negedge clk);
        chk("R8", "no extra job", {15'd0, busy}, 16'd0);
        chk("R8", "scoreboard drained", 16'(sb_q.size()), 16'd0);
        chk("R8", "cal after ignore", cal_reg, 16'd6000);
        finish_run();
    end

endmodule